// File: doc/BRIEF.md
# Bit-Parallel NFA Pattern Matcher

This block scans a stream of 8-bit characters, one per clock, and reports each point where the stream has just completed a substring matching the fixed pattern `A+[AB]{3}D`. The pattern means one or more `A`, then exactly three characters that are each `A` or `B`, then `D`. The block is built as a nondeterministic automaton with one flip-flop per automaton state. A lookup table indexed by the incoming character gives a class-hit bit for every state. Each state's next value is the OR of its predecessor activities, ANDed with its own class-hit bit, so every empty-string move settles in the same cycle as the character that causes it.

The start state is not a flip-flop. It is held active on every character, so a match may begin anywhere in the stream. The pattern is set by a package function that gives each state its character class and its predecessor set. The state count, character width and character codes are parameters.

Top module: `nfa_matcher`

## Requirements
- R1: While `rst_n` is low, and after it is released, all state flip-flops are clear and `match_o` is 0. A partial pattern fed before a reset does not complete a match after the reset.
- R2: The stream `A A B A D` (codes 0x41 0x41 0x42 0x41 0x44), with `in_valid` high on each character, raises `match_o` in the clock cycle that follows the `D`.
- R3: Matching is unanchored. A matching substring that is preceded by unrelated characters is still reported.
- R4: At least one `A` must come before the three `A`/`B` characters. `B B B D` does not match, and `A B B B D` does match.
- R5: Exactly three `A`/`B` characters must lie between the last leading `A` and the `D`. `A B B D` and `A B B B B D` do not match, and `A A A A A D` does match.
- R6: In a cycle where `in_valid` is low, all state flip-flops hold their values and `in_char` has no effect. A match split by invalid cycles is still reported after its final valid character.
- R7: `match_o` is high for exactly one cycle per completed match. It is high only in the cycle after a valid character that completes a match, including when `in_valid` drops in that cycle.
- R8: Only the exact codes 0x41 (`A`), 0x42 (`B`) and 0x44 (`D`) are recognised. Lowercase letters and other codes never advance any state.
- R9: Matches that follow each other directly are each reported. The `A` characters of a new match may arrive in the cycle in which the previous match is being reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when `in_char` holds a character to consume |
| in_char | input | 8 | Input character code |
| match_o | output | 1 | One-cycle pulse after the final character of a match |

## Verification
Two events can fall in the same cycle: the report of a completed match, and either a new thread starting from the always-active start state or `in_valid` going low. The bench provokes the first case by sending the next pattern's leading `A` right after a `D`. It provokes the second by dropping `in_valid` directly after a `D`, with junk left on `in_char`. In both cases the pulse must last exactly one cycle. A bench model built on a sliding history of the last five valid characters gives the expected value for every cycle, and that value is compared with `match_o` through a scoreboard queue.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

  localparam int CHAR_W     = 8;
  localparam int NUM_STATES = 5;
  localparam int ACCEPT_IDX = NUM_STATES - 1;
  localparam int TABLE_LEN  = 1 << CHAR_W;

  localparam logic [CHAR_W-1:0] CODE_A = 8'h41;
  localparam logic [CHAR_W-1:0] CODE_B = 8'h42;
  localparam logic [CHAR_W-1:0] CODE_D = 8'h44;

  typedef enum logic [1:0] {
    CLS_A  = 2'd0,
    CLS_AB = 2'd1,
    CLS_D  = 2'd2
  } charClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // consume one character
    logic seed;     // start state activity
  } ctrlStrobe_t;

  // character class accepted by each state
  function automatic charClass_t stateClass(input int s);
    if (s == 0) return CLS_A;
    else if (s == NUM_STATES - 1) return CLS_D;
    else return CLS_AB;
  endfunction

  // predecessor set: bit 0 is the start state, bit k+1 is state k
  function automatic logic [NUM_STATES:0] predMask(input int s);
    logic [NUM_STATES:0] m;
    m = '0;
    if (s == 0) begin
      m[0] = 1'b1;  // entered from start
      m[1] = 1'b1;  // self loop for one-or-more
    end else begin
      m[s] = 1'b1;  // chain from previous state
    end
    return m;
  endfunction

  function automatic logic classHit(input charClass_t cls, input logic [CHAR_W-1:0] ch);
    case (cls)
      CLS_A:   return ch == CODE_A;
      CLS_AB:  return (ch == CODE_A) || (ch == CODE_B);
      CLS_D:   return ch == CODE_D;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nfa_ctrl.sv
module nfa_ctrl
  import nfa_pkg::*;
(
  input  logic        inValid,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.advance = inValid;
    strobe.seed    = 1'b1;  // unanchored: start state always live
  end

endmodule

// File: rtl/nfa_datapath.sv
module nfa_datapath
  import nfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [CHAR_W-1:0] inChar,
  output logic              matchOut
);

  // character-indexed detection table
  logic [NUM_STATES-1:0] hitTable [TABLE_LEN];

  for (genvar c = 0; c < TABLE_LEN; c++) begin : g_char
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
      assign hitTable[c][s] = classHit(stateClass(s), CHAR_W'(c));
    end
  end

  logic [NUM_STATES-1:0] hitVec;
  assign hitVec = hitTable[inChar];

  logic [NUM_STATES-1:0] stateQ;
  logic [NUM_STATES-1:0] stateNext;
  logic [NUM_STATES:0]   activeVec;
  logic                  matchQ;

  assign activeVec = {stateQ, strobe.seed};

  // one AND per state; empty moves folded into the OR over predecessors
  for (genvar s = 0; s < NUM_STATES; s++) begin : g_next
    assign stateNext[s] = (|(activeVec & predMask(s))) & hitVec[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= '0;
      matchQ <= 1'b0;
    end else begin
      if (strobe.advance) stateQ <= stateNext;
      matchQ <= strobe.advance & stateNext[ACCEPT_IDX];
    end
  end

  assign matchOut = matchQ;

  // R6: frozen state while no character is consumed
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance |=> $stable(stateQ));

  // R7: a match pulse follows a consumed character
  assert_match_after_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
    matchQ |-> $past(strobe.advance));

  // R7: the accepting flip-flop is set whenever a match is reported
  assert_match_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    matchQ |-> stateQ[ACCEPT_IDX]);

  // R5: the accepting state only rises from the last chain state
  assert_chain_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stateQ[ACCEPT_IDX]) |-> $past(stateQ[ACCEPT_IDX-1]));

  // R8: the first state only rises on the A code
  assert_first_on_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stateQ[0]) |-> $past(inChar == CODE_A));

endmodule

// File: rtl/nfa_matcher.sv
module nfa_matcher
  import nfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              match_o
);

  ctrlStrobe_t strobe;

  nfa_ctrl u_ctrl (
    .inValid (in_valid),
    .strobe  (strobe)
  );

  nfa_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inChar   (in_char),
    .matchOut (match_o)
  );

endmodule

// File: tb/nfa_matcher_test.sv
module nfa_matcher_test;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic       match_o;

  nfa_matcher uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_char  (in_char),
    .match_o  (match_o)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  item_t  sbQueue[$];
  int     nChecks = 0;
  int     nFails  = 0;
  logic [7:0] hist[5];
  bit     done = 1'b0;

  function automatic bit isAB(input logic [7:0] c);
    return c == 8'h41 || c == 8'h42;
  endfunction

  task automatic clearHist();
    for (int i = 0; i < 5; i++) hist[i] = 8'h00;
  endtask

  // driver: one cycle of stimulus plus expected result
  task automatic drive(input bit v, input logic [7:0] c, input string req);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_char  = c;
    it.req   = req;
    it.exp   = 1'b0;
    if (v) begin
      for (int i = 0; i < 4; i++) hist[i] = hist[i+1];
      hist[4] = c;
      it.exp = (hist[0] == 8'h41) && isAB(hist[1]) && isAB(hist[2]) &&
               isAB(hist[3]) && (hist[4] == 8'h44);
    end
    sbQueue.push_back(it);
  endtask

  task automatic sendStr(input string s, input string req);
    for (int i = 0; i < s.len(); i++) drive(1'b1, s[i], req);
  endtask

  task automatic doReset(input int cycles);
    item_t it;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      it.exp = 1'b0;
      it.req = "R1";
      sbQueue.push_back(it);
    end
    clearHist();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (sbQueue.size() > 0) begin
      item_t it;
      it = sbQueue.pop_front();
      nChecks++;
      if (match_o !== it.exp) begin
        nFails++;
        $display("FAIL %s: match_o actual %b expected %b at %0t", it.req, match_o, it.exp, $time);
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    clearHist();
    // R1: reset state
    doReset(3);
    drive(1'b0, 8'h00, "R1");

    // R2: basic acceptance
    sendStr("AABAD", "R2");
    drive(1'b0, 8'h44, "R7");
    drive(1'b0, 8'h00, "R7");

    // R3: unanchored
    sendStr("xyzQAABBD", "R3");
    drive(1'b1, 8'h2e, "R7");

    // R4: leading A required
    sendStr("..BBBD", "R4");
    sendStr(".ABBBD", "R4");

    // R5: exact count of middle characters
    sendStr(".ABBD", "R5");
    sendStr(".ABBBBD", "R5");
    sendStr(".AAAAAD", "R5");

    // R6: freeze with junk on in_char
    sendStr(".AAB", "R6");
    drive(1'b0, 8'h44, "R6");
    drive(1'b0, 8'h42, "R6");
    drive(1'b0, 8'h2e, "R6");
    sendStr("A", "R6");
    drive(1'b0, 8'h41, "R6");
    sendStr("D", "R6");
    // R7: invalid right after completing character
    drive(1'b0, 8'h44, "R7");
    drive(1'b0, 8'h44, "R7");

    // R8: lowercase and near codes
    sendStr(".aabad", "R8");
    sendStr(".AACAD", "R8");
    sendStr(".AABAE", "R8");

    // R9: back-to-back matches
    sendStr("AAAADAAAADAABBD", "R9");
    sendStr("AAAAAAAD", "R9");

    // R1: partial pattern cut by reset
    sendStr(".AABA", "R1");
    doReset(2);
    sendStr("D", "R1");
    sendStr("BAD", "R1");

    // R2: again after reset
    sendStr("AABAD", "R2");
    drive(1'b0, 8'h00, "R7");
    drive(1'b0, 8'h00, "R7");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule